// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Protocol Engine

This block is the bus-facing controller of an 8192-byte nonvolatile memory that sits on a two-wire serial bus. It runs on a system clock that is much faster than the serial clock. It brings the raw SCL and SDA levels through two-flop synchronisers and finds start and stop conditions and clock edges on the synchronised levels. It answers with an open-drain pull-down enable on SDA.

After a start, the engine checks the address byte. The byte must carry the fixed device-type nibble 1010 and the three strap bits, and the write cycle must not be busy. In a write transaction it collects a high and a low word-address byte. Every complete data byte that follows goes to a separate page-write block with its address. A stop ends such a transaction and sends a commit strobe. In a read transaction the engine fetches bytes through a synchronous read port and shifts them out MSB first. It keeps going for as long as the master acknowledges. The word pointer is kept between transactions. A current-address read therefore continues where the last access stopped, and a write that ends after its word address, followed by a repeated start and a read, gives a random read.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset, SDA is released, no strobe is active, and the word pointer is 0, so a current-address read returns the byte at address 0.
- R2: A start or stop that arrives in the middle of a byte aborts the transfer. A stop in the middle of a data byte produces neither a write strobe nor a commit.
- R3: The device address byte (MSB first) is acknowledged only when bits 7:4 equal 1010 and bits 3:1 equal strap_i; bit 0 = 1 selects read. On a mismatch, SDA is released and every bit is ignored until the next start.
- R4: While busy_i is high, the device address is not acknowledged. Once busy_i is low, it is acknowledged again.
- R5: In a write transaction, the first byte after the address holds word-address bits 12:8 in its low five bits, and its top three bits are ignored. The second byte holds bits 7:0. The slave acknowledges both bytes.
- R6: Each complete write data byte is acknowledged and produces a one-cycle wr_valid_o with its address and data. wr_first_o is set only on the first data byte of a transaction. The address then moves up by one and wraps within its 32-byte page.
- R7: A stop after at least one write data byte produces exactly one commit pulse. A stop after a write that carried no data byte produces none, and a repeated start drops any pending commit.
- R8: Read data goes out MSB first. The SDA drive changes only while SCL is low, so SDA stays stable while SCL is high.
- R9: When the master acknowledges a read byte (SDA low in the ninth clock), the next byte follows. When it does not acknowledge, SDA is released and the read ends.
- R10: During a read the pointer goes from 0x1FFF to 0x0000.
- R11: Between transactions the pointer holds the last accessed address plus one. The second word-address byte of a write loads the pointer.
- R12: After an aborted transfer, a new start with a full transaction works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock level from the bus |
| sda_i | input | 1 | Serial data level from the bus |
| strap_i | input | 3 | Pin-strapped device address bits |
| busy_i | input | 1 | Internal write cycle in progress |
| sda_pull_o | output | 1 | Pull SDA low when high |
| wr_valid_o | output | 1 | One-cycle strobe for a received data byte |
| wr_first_o | output | 1 | Strobed byte is the first of its transaction |
| wr_addr_o | output | 13 | Address of the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |
| wr_commit_o | output | 1 | One-cycle strobe: start the write cycle |
| mem_rd_en_o | output | 1 | Read request to the array |
| mem_rd_addr_o | output | 13 | Read address |
| mem_rd_data_i | input | 8 | Read data, valid the cycle after the request |

## Verification
A wrong state in the byte sequencer shows up within one serial bit. An acknowledge appears where none belongs or is missing, or read data is shifted by one bit. The master sees this at the next SCL high phase. A wrong pointer shows up only in the next access. The bench therefore follows every write, dummy write and abort with a current-address read and compares the returned byte against the address pattern. An SDA drive that changes in the wrong phase would look like a false start or stop, so SDA is sampled twice in every high phase of a read.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WDAT, ST_ACK, ST_RDAT, ST_MACK
  } twi_st_e;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff <= 2'b11;  // bus idles high
      else         ff <= {ff[0], d_i[g]};
    end
    assign q_o[g] = ff[1];
  end
endmodule

// File: rtl/twi_cond_det.sv
module twi_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end
  assign scl_rise_o = !scl_q && scl_s_i;
  assign scl_fall_o = scl_q && !scl_s_i;
  assign start_o    = scl_q && scl_s_i && sda_q && !sda_s_i;
  assign stop_o     = scl_q && scl_s_i && !sda_q && sda_s_i;
endmodule

// File: rtl/twi_word_ptr.sv
module twi_word_ptr #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_rd_i,
  input  logic              inc_wr_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [PAGE_W-1:0] page_nxt;
  assign page_nxt = ptr_o[PAGE_W-1:0] + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_o <= '0;
    else if (load_i)   ptr_o <= load_val_i;
    else if (inc_rd_i) ptr_o <= ptr_o + 1'b1;              // full-array wrap
    else if (inc_wr_i) ptr_o <= {ptr_o[ADDR_W-1:PAGE_W], page_nxt};  // page wrap
  end
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
  import twi_eeprom_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  output logic              sda_pull_o,
  output logic              wr_valid_o,
  output logic              wr_first_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o,
  output logic              mem_rd_en_o,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic [7:0]        mem_rd_data_i
);
  localparam int HI_W = ADDR_W - 8;

  logic [1:0] lvl;
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  twi_sync #(.W(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({scl_i, sda_i}), .q_o(lvl)
  );
  assign scl_s = lvl[1];
  assign sda_s = lvl[0];

  twi_cond_det u_cond (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  twi_st_e         state, ack_next;
  logic [2:0]      bit_cnt;
  logic [6:0]      shreg;
  logic [7:0]      tx;
  logic [HI_W-1:0] addr_hi;
  logic            ack_on, ack_go, wr_pend, rd_cap, mack;

  logic [7:0]        byte_in;
  logic              rx_state, byte_done, dev_hit, rd_issue, wr_fire, ptr_load;
  logic [ADDR_W-1:0] ptr;

  always_comb begin
    byte_in   = {shreg, sda_s};
    rx_state  = (state == ST_DEV) || (state == ST_AHI) ||
                (state == ST_ALO) || (state == ST_WDAT);
    byte_done = rx_state && scl_rise && (bit_cnt == 3'd7) && !start_det && !stop_det;
    dev_hit   = (byte_in[7:4] == DEV_TYPE) && (byte_in[3:1] == strap_i) && !busy_i;
    rd_issue  = (byte_done && (state == ST_DEV) && dev_hit && byte_in[0]) ||
                ((state == ST_MACK) && scl_rise && !sda_s && !start_det && !stop_det);
    wr_fire   = byte_done && (state == ST_WDAT);
    ptr_load  = byte_done && (state == ST_ALO);
  end

  twi_word_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(ptr_load), .load_val_i({addr_hi, byte_in}),
    .inc_rd_i(rd_issue), .inc_wr_i(wr_fire), .ptr_o(ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state         <= ST_IDLE;
      ack_next      <= ST_IDLE;
      bit_cnt       <= '0;
      shreg         <= '0;
      tx            <= '0;
      addr_hi       <= '0;
      ack_on        <= 1'b0;
      ack_go        <= 1'b0;
      wr_pend       <= 1'b0;
      rd_cap        <= 1'b0;
      mack          <= 1'b0;
      sda_pull_o    <= 1'b0;
      wr_valid_o    <= 1'b0;
      wr_first_o    <= 1'b0;
      wr_addr_o     <= '0;
      wr_data_o     <= '0;
      wr_commit_o   <= 1'b0;
      mem_rd_en_o   <= 1'b0;
      mem_rd_addr_o <= '0;
    end else begin
      wr_valid_o  <= 1'b0;
      wr_commit_o <= 1'b0;
      mem_rd_en_o <= rd_issue;
      if (rd_issue) mem_rd_addr_o <= ptr;
      rd_cap <= mem_rd_en_o;
      if (rd_cap) tx <= mem_rd_data_i;

      if (stop_det) begin
        state       <= ST_IDLE;
        sda_pull_o  <= 1'b0;
        ack_on      <= 1'b0;
        wr_commit_o <= wr_pend;
        wr_pend     <= 1'b0;
      end else if (start_det) begin
        state      <= ST_DEV;
        bit_cnt    <= '0;
        sda_pull_o <= 1'b0;
        ack_on     <= 1'b0;
        wr_pend    <= 1'b0;
      end else begin
        unique case (state)
          ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
            if (scl_rise) begin
              shreg   <= byte_in[6:0];
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == 3'd7) begin
                state  <= ST_ACK;
                ack_on <= 1'b0;
                ack_go <= 1'b1;
                unique case (state)
                  ST_DEV: begin
                    ack_go   <= dev_hit;
                    ack_next <= byte_in[0] ? ST_RDAT : ST_AHI;
                  end
                  ST_AHI: begin
                    addr_hi  <= byte_in[HI_W-1:0];
                    ack_next <= ST_ALO;
                  end
                  ST_ALO:  ack_next <= ST_WDAT;
                  default: begin
                    ack_next   <= ST_WDAT;
                    wr_valid_o <= 1'b1;
                    wr_first_o <= !wr_pend;
                    wr_addr_o  <= ptr;
                    wr_data_o  <= byte_in;
                    wr_pend    <= 1'b1;
                  end
                endcase
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (!ack_on) begin
                if (ack_go) begin
                  sda_pull_o <= 1'b1;
                  ack_on     <= 1'b1;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                ack_on     <= 1'b0;
                bit_cnt    <= '0;
                state      <= ack_next;
                sda_pull_o <= (ack_next == ST_RDAT) ? !tx[7] : 1'b0;
              end
            end
          end
          ST_RDAT: begin
            if (scl_fall) begin
              if (bit_cnt == 3'd7) begin
                sda_pull_o <= 1'b0;
                bit_cnt    <= '0;
                state      <= ST_MACK;
              end else begin
                bit_cnt    <= bit_cnt + 1'b1;
                tx         <= {tx[6:0], 1'b0};
                sda_pull_o <= !tx[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) mack <= !sda_s;
            if (scl_fall) begin
              if (mack) begin
                state      <= ST_RDAT;
                bit_cnt    <= '0;
                sda_pull_o <= !tx[7];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_eeprom_slave_chk.sv
module twi_eeprom_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic sda_pull_o,
  input logic wr_valid_o,
  input logic wr_commit_o,
  input logic mem_rd_en_o
);
  // R8
  pull_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_s));

  // R6
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);

  // R7
  commit_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |-> !wr_valid_o);

  // R7
  commit_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |=> !wr_commit_o);

  // R9
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_en_o |=> !mem_rd_en_o);
endmodule

bind twi_eeprom_slave twi_eeprom_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .sda_pull_o(sda_pull_o),
  .wr_valid_o(wr_valid_o), .wr_commit_o(wr_commit_o), .mem_rd_en_o(mem_rd_en_o)
);

// File: tb/twi_eeprom_slave_tb.sv
module twi_eeprom_slave_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, scl, m_pull, busy;
  logic        sda_pull, wr_valid, wr_first, wr_commit, rd_en;
  logic [12:0] wr_addr, rd_addr;
  logic [7:0]  wr_data, rd_q;
  wire         sda_bus = !(m_pull || sda_pull);

  twi_eeprom_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .strap_i(3'b101), .busy_i(busy), .sda_pull_o(sda_pull),
    .wr_valid_o(wr_valid), .wr_first_o(wr_first), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .wr_commit_o(wr_commit),
    .mem_rd_en_o(rd_en), .mem_rd_addr_o(rd_addr), .mem_rd_data_i(rd_q)
  );

  function automatic logic [7:0] pat(input logic [12:0] a);
    return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h5A;
  endfunction

  always @(posedge clk) if (rd_en) rd_q <= pat(rd_addr);

  logic [12:0] log_a [16];
  logic [7:0]  log_d [16];
  logic        log_f [16];
  int wr_n = 0, cm_n = 0;
  always @(posedge clk) begin
    if (wr_valid && wr_n < 16) begin
      log_a[wr_n] <= wr_addr;
      log_d[wr_n] <= wr_data;
      log_f[wr_n] <= wr_first;
      wr_n <= wr_n + 1;
    end
    if (wr_commit) cm_n <= cm_n + 1;
  end

  int checks = 0, errs = 0, unstable = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start;
    m_pull = 1'b0; tick(8); scl = 1'b1; tick(16);
    m_pull = 1'b1; tick(16); scl = 1'b0; tick(4);
  endtask

  task automatic m_stop;
    tick(4); m_pull = 1'b1; tick(12); scl = 1'b1; tick(16);
    m_pull = 1'b0; tick(16);
  endtask

  task automatic m_bit_out(input logic b);
    tick(4); m_pull = !b; tick(12); scl = 1'b1; tick(16); scl = 1'b0;
  endtask

  task automatic m_bit_in(output logic b);
    logic s1;
    tick(4); m_pull = 1'b0; tick(12); scl = 1'b1; tick(8);
    s1 = sda_bus; tick(8); b = sda_bus;
    if (s1 !== b) unstable++;
    scl = 1'b0;
  endtask

  task automatic m_write_byte(input logic [7:0] v, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) m_bit_out(v[i]);
    m_bit_in(a);
    acked = !a;
  endtask

  task automatic m_read_byte(input logic ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) m_bit_in(v[i]);
    m_bit_out(!ack);
  endtask

  task automatic cur_read(input string req, input logic [7:0] exp);
    logic a; logic [7:0] v;
    m_start; m_write_byte(8'hAB, a);
    chk({req, " read ack"}, a, 1'b1);
    m_read_byte(1'b0, v);
    chk({req, " read data"}, v, exp);
    m_stop;
  endtask

  // {address byte, expected ack}
  localparam logic [8:0] ADDR_VEC [7] = '{
    {8'hAA, 1'b1}, {8'hA0, 1'b0}, {8'hBA, 1'b0}, {8'h2A, 1'b0},
    {8'hAE, 1'b0}, {8'hA8, 1'b0}, {8'hEA, 1'b0}
  };

  initial begin
    logic a; logic [7:0] v;
    rst_n = 1'b0; scl = 1'b1; m_pull = 1'b0; busy = 1'b0;
    tick(5); rst_n = 1'b1; tick(5);

    // R1 reset state
    chk("R1 pull", sda_pull, 1'b0);
    chk("R1 wr_valid", wr_valid, 1'b0);
    chk("R1 commit", wr_commit, 1'b0);
    cur_read("R1", pat(13'h0000));

    // R3 address compare table
    for (int i = 0; i < 7; i++) begin
      m_start; m_write_byte(ADDR_VEC[i][8:1], a);
      chk("R3 addr ack", a, ADDR_VEC[i][0]);
      m_stop;
    end
    chk("R7 no commit on empty write", cm_n, 0);

    // R5 R6 R7 page write with wrap and ignored top bits
    m_start; m_write_byte(8'hAA, a);
    m_write_byte(8'hE3, a); chk("R5 hi ack", a, 1'b1);
    m_write_byte(8'h1E, a); chk("R5 lo ack", a, 1'b1);
    m_write_byte(8'h11, a); chk("R6 d0 ack", a, 1'b1);
    m_write_byte(8'h22, a); chk("R6 d1 ack", a, 1'b1);
    m_write_byte(8'h33, a); chk("R6 d2 ack", a, 1'b1);
    m_stop;
    chk("R6 count", wr_n, 3);
    chk("R5 addr0", log_a[0], 13'h031E);
    chk("R6 addr1", log_a[1], 13'h031F);
    chk("R6 page wrap", log_a[2], 13'h0300);
    chk("R6 data", {log_d[0], log_d[1], log_d[2]}, 24'h112233);
    chk("R6 first flags", {log_f[0], log_f[1], log_f[2]}, 3'b100);
    chk("R7 commit", cm_n, 1);
    cur_read("R11 after write", pat(13'h0301));

    // R11 R10 R9 random read with sequential wrap
    m_start; m_write_byte(8'hAA, a);
    m_write_byte(8'h1F, a); m_write_byte(8'hFE, a);
    m_start; m_write_byte(8'hAB, a); chk("R11 rnd ack", a, 1'b1);
    unstable = 0;
    m_read_byte(1'b1, v); chk("R11 rnd data", v, pat(13'h1FFE));
    m_read_byte(1'b1, v); chk("R9 seq data", v, pat(13'h1FFF));
    m_read_byte(1'b0, v); chk("R10 wrap data", v, pat(13'h0000));
    tick(8);
    chk("R9 released after nack", sda_pull, 1'b0);
    chk("R8 stable while SCL high", unstable, 0);
    m_stop;
    chk("R7 dummy write no commit", cm_n, 1);
    cur_read("R11 after read", pat(13'h0001));

    // R4 busy polling
    busy = 1'b1;
    m_start; m_write_byte(8'hAA, a); chk("R4 busy nack", a, 1'b0); m_stop;
    busy = 1'b0;
    m_start; m_write_byte(8'hAA, a); chk("R4 ready ack", a, 1'b1); m_stop;

    // R3 mismatch ignores bits until next start
    m_start; m_write_byte(8'hA0, a);
    m_write_byte(8'hAA, a); chk("R3 ignored after mismatch", a, 1'b0);
    m_stop;

    // R12 R2 start in mid byte, then full write
    m_start; m_bit_out(1'b1); m_bit_out(1'b0); m_bit_out(1'b1); m_bit_out(1'b0);
    m_start; m_write_byte(8'hAA, a); chk("R12 ack after abort", a, 1'b1);
    m_write_byte(8'h00, a); m_write_byte(8'h40, a);
    m_write_byte(8'h77, a); chk("R12 data ack", a, 1'b1);
    m_stop;
    chk("R12 write addr", log_a[3], 13'h0040);
    chk("R12 write data", log_d[3], 8'h77);
    chk("R12 commit", cm_n, 2);

    // R2 stop in mid data byte
    m_start; m_write_byte(8'hAA, a); m_write_byte(8'h00, a); m_write_byte(8'h45, a);
    m_bit_out(1'b1); m_bit_out(1'b1); m_bit_out(1'b0); m_bit_out(1'b1);
    m_stop;
    chk("R2 no strobe", wr_n, 4);
    chk("R2 no commit", cm_n, 2);
    cur_read("R11 pointer load", pat(13'h0045));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule